// File: doc/BRIEF.md
# Four-Channel Shared-Timebase PWM Generator

The block produces four pulse-width-modulated outputs and four complementary outputs from one timebase. A single prescaler divides the clock, and one up-counter runs from zero to a programmable reload value and then wraps. Each channel compares the shared count with its own compare value. Because the prescaler and the period are common, changing either one changes every channel at once.

Software programs the block through a simple write port. The prescaler and compare values are held in shadow registers, and so is the reload value when its preload is enabled. These shadows move into the active timebase at a counter wrap, or at once when a forced update is written. Each channel has an enable and a polarity bit for its main output, and a separate enable and polarity bit for its complementary output. A global output gate holds all eight pins low while it is clear. A counter-enable input freezes the timebase.

Top module: `pwm4_core`

## Requirements
- R1: During and after synchronous reset, every main and complementary output is 0, and all registers, the prescaler count and the counter are 0.
- R2: The counter advances once every psc+1 clocks and wraps to 0 after reaching the reload value, so the period is (reload+1)*(psc+1) clocks. A channel's internal reference is active while count < compare.
- R3: A compare value greater than the reload value keeps the reference active for the whole period. A compare value of 0 keeps it inactive.
- R4: The channel word at address 4 gives channel n four bits starting at bit 4n: bit 4n is the main enable, 4n+1 the main polarity, 4n+2 the complementary enable and 4n+3 the complementary polarity. An enabled main output is the reference XOR its polarity bit. A disabled main output drives its polarity bit.
- R5: An enabled complementary output is the inverted reference XOR its own polarity bit. A disabled complementary output drives its own polarity bit.
- R6: While bit 1 (output gate) of the configuration word at address 0 is clear, all eight outputs are 0.
- R7: Writing 1 to bit 0 of address 1 is a forced update. On that clock edge the prescaler count and the counter clear to 0, and the shadowed prescaler, reload and compare values, as held before the edge, become active.
- R8: When bit 0 (reload preload) of address 0 is set, a value written to the reload register at address 3 takes effect only at the next wrap or forced update. When the bit is clear, it takes effect on the next count, and a counter already at or above the new value wraps to 0 on its next advance.
- R9: The prescaler (address 2) and the compare values (address 8+n for channel n) written without a forced update take effect only at the next wrap.
- R10: While cnt_en is low, the prescaler count and the counter hold their values. Counting resumes from those values when cnt_en returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Timebase run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Register write data |
| pwm_o | output | NCH | Main channel outputs |
| pwm_n_o | output | NCH | Complementary channel outputs |

## Verification
The hardest case to reach from the ports is a reload or compare write that lands while a period is in progress. The write must arrive at a known count, so that the deferred (preload) and immediate (no preload) paths give different pulse patterns. The bench aligns the counter with a forced update. It then issues the writes on chosen cycles counted from that edge, which lets the expected count be derived arithmetically for every later cycle. The same alignment is used for a sweep over prescaler, reload and compare values with varied control words, and for a mid-period hold of cnt_en.

// File: rtl/pwm4_pkg.sv
`timescale 1ns/1ps
package pwm4_pkg;
    localparam int CNT_W_DEF = 16;
    localparam int NCH_DEF   = 4;
    localparam int ADDR_W    = 4;
    localparam int CFG_BITS  = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG      = 4'd0,
        REG_EVT      = 4'd1,
        REG_PSC      = 4'd2,
        REG_ARR      = 4'd3,
        REG_CHCFG    = 4'd4,
        REG_CMP_BASE = 4'd8
    } reg_addr_e;

    // per-channel control nibble, bit 0 = main enable
    typedef struct packed {
        logic npol;
        logic nen;
        logic pol;
        logic en;
    } chan_cfg_t;

    typedef struct packed {
        logic gate;
        logic arr_pre;
    } glob_cfg_t;

    function automatic logic drive_level(logic gate, logic on, logic lvl, logic inv);
        return gate & (on ? (lvl ^ inv) : inv);
    endfunction
endpackage

// File: rtl/pwm4_regs.sv
`timescale 1ns/1ps
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int NCH   = NCH_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    output glob_cfg_t                    gcfg,
    output logic                         force_evt,
    output logic [CNT_W-1:0]             psc_sh,
    output logic [CNT_W-1:0]             arr_sh,
    output logic [CFG_BITS*NCH-1:0]      chcfg,
    output logic [NCH-1:0][CNT_W-1:0]    cmp_sh
);
    localparam int CHW = CFG_BITS * NCH;

    assign force_evt = wr_en && (wr_addr == REG_EVT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg   <= '0;
            psc_sh <= '0;
            arr_sh <= '0;
            chcfg  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CFG:   gcfg   <= glob_cfg_t'(wr_data[1:0]);
                REG_PSC:   psc_sh <= wr_data;
                REG_ARR:   arr_sh <= wr_data;
                REG_CHCFG: chcfg  <= wr_data[CHW-1:0];
                default:   ;
            endcase
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(REG_CMP_BASE) + i);
        always_ff @(posedge clk) begin
            if (rst)
                cmp_sh[i] <= '0;
            else if (wr_en && (wr_addr == MY_ADDR))
                cmp_sh[i] <= wr_data;
        end
    end
endmodule

// File: rtl/pwm4_timebase.sv
`timescale 1ns/1ps
module pwm4_timebase
    import pwm4_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             force_evt,
    input  logic             arr_pre,
    input  logic [CNT_W-1:0] psc_sh,
    input  logic [CNT_W-1:0] arr_sh,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] arr_eff,
    output logic             tick,
    output logic             wrap,
    output logic             update
);
    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] psc_act;
    logic [CNT_W-1:0] arr_act;

    assign tick    = cnt_en && (pre_q >= psc_act);
    assign arr_eff = arr_pre ? arr_act : arr_sh;
    assign wrap    = tick && (cnt_q >= arr_eff);
    assign update  = force_evt | wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            psc_act <= '0;
            arr_act <= '0;
        end else if (force_evt) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            psc_act <= psc_sh;
            arr_act <= arr_sh;
        end else if (cnt_en) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (wrap) begin
                cnt_q   <= '0;
                psc_act <= psc_sh;
                arr_act <= arr_sh;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm4_chan.sv
`timescale 1ns/1ps
module pwm4_chan
    import pwm4_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             update,
    input  logic             gate,
    input  chan_cfg_t        cfg,
    input  logic [CNT_W-1:0] cmp_sh,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_act,
    output logic             out_p,
    output logic             out_n
);
    logic ref_lvl;

    always_ff @(posedge clk) begin
        if (rst)
            cmp_act <= '0;
        else if (update)
            cmp_act <= cmp_sh;
    end

    assign ref_lvl = cnt_q < cmp_act;
    assign out_p   = drive_level(gate, cfg.en,  ref_lvl,  cfg.pol);
    assign out_n   = drive_level(gate, cfg.nen, !ref_lvl, cfg.npol);
endmodule

// File: rtl/pwm4_core.sv
`timescale 1ns/1ps
module pwm4_core
    import pwm4_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int NCH   = NCH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NCH-1:0]    pwm_o,
    output logic [NCH-1:0]    pwm_n_o
);
    glob_cfg_t                 gcfg;
    logic                      force_evt;
    logic [CNT_W-1:0]          psc_sh;
    logic [CNT_W-1:0]          arr_sh;
    logic [CFG_BITS*NCH-1:0]   chcfg;
    logic [NCH-1:0][CNT_W-1:0] cmp_sh;
    logic [NCH-1:0][CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0]          cnt_q;
    logic [CNT_W-1:0]          arr_eff;
    logic                      tick;
    logic                      wrap;
    logic                      update;

    pwm4_regs #(.CNT_W(CNT_W), .NCH(NCH)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gcfg(gcfg), .force_evt(force_evt),
        .psc_sh(psc_sh), .arr_sh(arr_sh), .chcfg(chcfg), .cmp_sh(cmp_sh)
    );

    pwm4_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .force_evt(force_evt),
        .arr_pre(gcfg.arr_pre), .psc_sh(psc_sh), .arr_sh(arr_sh),
        .cnt_q(cnt_q), .arr_eff(arr_eff), .tick(tick), .wrap(wrap),
        .update(update)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm4_chan #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .update(update), .gate(gcfg.gate),
            .cfg(chan_cfg_t'(chcfg[CFG_BITS*i +: CFG_BITS])),
            .cmp_sh(cmp_sh[i]), .cnt_q(cnt_q), .cmp_act(cmp_act[i]),
            .out_p(pwm_o[i]), .out_n(pwm_n_o[i])
        );
    end
endmodule

// File: rtl/pwm4_core_chk.sv
`timescale 1ns/1ps
module pwm4_core_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      cnt_en,
    input logic                      force_evt,
    input logic                      tick,
    input logic                      wrap,
    input logic                      gate,
    input logic [CNT_W-1:0]          cnt_q,
    input logic [NCH-1:0][CNT_W-1:0] cmp_act,
    input logic [NCH-1:0]            pwm_o,
    input logic [NCH-1:0]            pwm_n_o
);
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt_q == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wrap && !force_evt) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    p_force_clear_r7: assert property (@(posedge clk) disable iff (rst)
        force_evt |=> cnt_q == '0);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !force_evt) |=> $stable(cnt_q));

    p_gate_low_r6: assert property (@(posedge clk) disable iff (rst)
        !gate |-> (pwm_o == '0 && pwm_n_o == '0));

    p_cmp_shadow_r9: assert property (@(posedge clk) disable iff (rst)
        !(wrap || force_evt) |=> $stable(cmp_act));
endmodule

bind pwm4_core pwm4_core_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .force_evt(force_evt),
    .tick(tick), .wrap(wrap), .gate(gcfg.gate), .cnt_q(cnt_q),
    .cmp_act(cmp_act), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
);

// File: tb/tb_pwm4_core.sv
`timescale 1ns/1ps
module tb_pwm4_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm_o, pwm_n_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          cmpv [4];
    logic [15:0] cfgw;
    logic        gate_b;

    pwm4_core dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_p(int cnt);
        logic [3:0] r;
        for (int c = 0; c < 4; c++) begin
            logic rf = cnt < cmpv[c];
            r[c] = gate_b & (cfgw[4*c] ? (rf ^ cfgw[4*c+1]) : cfgw[4*c+1]);
        end
        return r;
    endfunction

    function automatic logic [3:0] exp_n(int cnt);
        logic [3:0] r;
        for (int c = 0; c < 4; c++) begin
            logic rf = cnt < cmpv[c];
            r[c] = gate_b & (cfgw[4*c+2] ? (!rf ^ cfgw[4*c+3]) : cfgw[4*c+3]);
        end
        return r;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #2 wr_en = 1'b0;
    endtask

    task automatic setup(int p, int a, logic pre, logic g);
        wr(4'd0, {14'd0, g, pre});
        gate_b = g;
        wr(4'd2, 16'(p));
        wr(4'd3, 16'(a));
        for (int c = 0; c < 4; c++) wr(4'(8 + c), 16'(cmpv[c]));
        wr(4'd4, cfgw);
        wr(4'd1, 16'd1);           // R7 forced update aligns the timebase
    endtask

    // R8 / R9: reload and compare writes landing mid-period
    task automatic mid_period(logic pre);
        int cnt, c1;
        cmpv[0] = 5; cmpv[1] = 2; cmpv[2] = 0; cmpv[3] = 0;
        cfgw = 16'h0011;
        setup(0, 3, pre, 1'b1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pre) begin
                cnt = (k < 4) ? k : (k - 4) % 8;
                c1  = (k < 4) ? 2 : 4;
            end else begin
                if (k < 8)       cnt = k;
                else if (k < 13) cnt = k - 8;
                else if (k == 13) cnt = 5;
                else             cnt = (k - 14) % 3;
                c1 = (k < 8) ? 2 : 4;
            end
            cmpv[1] = c1;
            chk(pre ? "R8 preload reload / R9 compare shadow" : "R8 immediate reload / R9 compare shadow",
                pwm_o, exp_p(cnt));
            if (k == 1) begin wr_en = 1'b1; wr_addr = 4'd3; wr_data = 16'd7; end
            if (k == 2) begin wr_addr = 4'd9; wr_data = 16'd4; end
            if (k == 3) wr_en = 1'b0;
            if (!pre && k == 12) begin wr_en = 1'b1; wr_addr = 4'd3; wr_data = 16'd2; end
            if (!pre && k == 13) wr_en = 1'b0;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int idx = 0;
        // R1 reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in reset main", pwm_o, 4'b0);
        chk("R1 in reset comp", pwm_n_o, 4'b0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 after reset main", pwm_o, 4'b0);
        chk("R1 after reset comp", pwm_n_o, 4'b0);

        // R2 R3 R4 R5 R7 sweep
        for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < 5; a++) begin
                for (int c = 0; c <= a + 2; c++) begin
                    for (int ch = 0; ch < 4; ch++) cmpv[ch] = (c + ch) % (a + 3);
                    cfgw = 16'((idx * 40503) & 16'hFFFF);
                    if (idx % 4 != 0) cfgw = cfgw | 16'h5555;
                    setup(p, a, 1'(idx % 2), 1'b1);
                    for (int k = 0; k < 2 * (a + 1) * (p + 1); k++) begin
                        int cnt;
                        @(negedge clk);
                        cnt = (k / (p + 1)) % (a + 1);
                        chk((c == 0 || c > a) ? "R3 R4 main edge compare" : "R2 R4 main",
                            pwm_o, exp_p(cnt));
                        chk("R5 complementary", pwm_n_o, exp_n(cnt));
                    end
                    idx++;
                end
            end
        end

        // R6 gate low forces all outputs to 0
        cmpv[0] = 2; cmpv[1] = 0; cmpv[2] = 9; cmpv[3] = 1;
        cfgw = 16'hFFFF;
        setup(0, 3, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R6 gate main", pwm_o, 4'b0);
            chk("R6 gate comp", pwm_n_o, 4'b0);
        end

        mid_period(1'b1);
        mid_period(1'b0);

        // R10 counter hold
        cmpv[0] = 3; cmpv[1] = 0; cmpv[2] = 0; cmpv[3] = 0;
        cfgw = 16'h0001;
        setup(1, 7, 1'b0, 1'b1);
        for (int k = 0; k < 17; k++) begin
            int cnt;
            @(negedge clk);
            if (k <= 4)       cnt = k / 2;
            else if (k <= 15) cnt = 2;
            else              cnt = 3;
            chk("R10 hold", pwm_o, exp_p(cnt));
            if (k == 4)  cnt_en = 1'b0;
            if (k == 14) cnt_en = 1'b1;
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule